// File: doc/BRIEF.md
# Qualified-Storage Capture Engine

This block is an on-chip debug recorder. Once armed, it watches a probe word every clock and writes selected samples into an internal circular sample memory. It stops recording when a trigger condition occurs. Which cycles are written depends on a storage qualifier. Which cycle ends the capture depends on a trigger. Both are built from the same bank of masked comparators, called match units. The qualifier and the trigger are evaluated separately, so a capture can end on a cycle that is not itself recorded. A slow strobe can serve as the qualifier, so that a full memory of strobed events covers a time span far longer than the memory depth in clocks.

After the capture ends, the memory contents are read through an age-ordered port, and the number of valid entries is shown on a count output. A new arm pulse clears the capture and starts it again.

Top module: `qcap_top`

## Requirements
- R1: With `qual_en` low, every clock cycle in the armed state writes the probe word, and this includes the trigger cycle.
- R2: With `qual_en` high, a cycle writes only when all match units selected in `qual_sel` hit. Bit i of `qual_sel` selects unit i. An all-zero `qual_sel` qualifies every cycle. Unqualified cycles leave no entry.
- R3: Match unit i hits when the probe and its compare value (`cmp_val[i*DATA_W +: DATA_W]`) agree on every bit set in its care mask (`cmp_care[i*DATA_W +: DATA_W]`). Bits with a care value of 0 are ignored.
- R4: The trigger fires whatever the state of the qualifier. A trigger on an unqualified cycle moves the block to done, and that cycle is not stored. A trigger on a qualified cycle stores that sample as the newest entry.
- R5: The trigger is the AND of the match units selected in `trig_sel`, and an all-zero `trig_sel` never fires. Putting the qualifying unit into `trig_sel` restricts the trigger to qualified cycles.
- R6: The memory holds DEPTH entries (default 1024) and is written circularly. `stored` counts up to DEPTH and stays there, and later writes replace the oldest entries.
- R7: `done` rises in the cycle after the trigger cycle. While done, nothing is written and `stored` holds, until the next arm pulse.
- R8: An arm pulse, in any state, clears `stored` to 0 and lowers `done`. Storage begins on the following cycle, and the arm cycle itself is never stored.
- R9: `rd_addr` is an age index, where 0 is the oldest stored entry. `rd_data` shows that entry one clock later while `done` is high. It shows 0 when the block is not done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start or restart a capture (one-cycle pulse) |
| probe | input | DATA_W | Observed data word |
| cmp_val | input | N_MATCH*DATA_W | Compare values, unit i at slice i |
| cmp_care | input | N_MATCH*DATA_W | Care masks, unit i at slice i |
| qual_en | input | 1 | Enable storage qualification |
| qual_sel | input | N_MATCH | Units ANDed into the qualifier |
| trig_sel | input | N_MATCH | Units ANDed into the trigger |
| done | output | 1 | Capture finished |
| stored | output | $clog2(DEPTH)+1 | Number of valid entries |
| rd_addr | input | $clog2(DEPTH) | Age index to read |
| rd_data | output | DATA_W | Registered read data |

## Verification
A wrong write pointer shows up only after the capture, when the age-ordered readback returns a rotated or shifted sequence. For that reason every scenario reads back every stored entry. A wrong qualifier or match decision changes `stored` within one clock, and the final count shows it. A wrong stop decision shows on `done` one cycle after the trigger cycle, or shows as extra entries after it. Wrap-around errors appear only past DEPTH writes, so one run fills the memory densely and another fills it with sparse qualified events.

// File: rtl/qcap_pkg.sv
package qcap_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_DONE  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic qual;
        logic trig;
    } cap_cond_t;
endpackage

// File: rtl/qcap_match.sv
module qcap_match #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] probe,
    input  logic [DATA_W-1:0] value,
    input  logic [DATA_W-1:0] care,
    output logic              hit
);
    always_comb hit = ((probe ^ value) & care) == '0;
endmodule

// File: rtl/qcap_store.sv
module qcap_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)        rdata <= '0;
        else if (rd_en) rdata <= mem[raddr];
        else            rdata <= '0;
    end

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> rdata == '0);
endmodule

// File: rtl/qcap_ctrl.sv
module qcap_ctrl
    import qcap_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          arm,
    input  cap_cond_t     cond,
    output cap_state_e    state,
    output logic          wr_en,
    output logic [AW-1:0] wptr,
    output logic [AW:0]   fill
);
    localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_comb wr_en = (state == CAP_ARMED) && !arm && cond.qual;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= CAP_IDLE;
            wptr  <= '0;
            fill  <= '0;
        end else if (arm) begin
            state <= CAP_ARMED;
            wptr  <= '0;
            fill  <= '0;
        end else if (state == CAP_ARMED) begin
            if (cond.qual) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
                if (fill != FULL) fill <= fill + 1'b1;
            end
            if (cond.trig) state <= CAP_DONE;
        end
    end

    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL);
    // R4
    trig_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_ARMED && cond.trig && !arm) |=> state == CAP_DONE);
    // R2
    unqual_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_ARMED && !cond.qual && !arm) |=> $stable(wptr) && $stable(fill));
    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == CAP_DONE && !arm) |=> state == CAP_DONE && $stable(fill) && $stable(wptr));
    // R8
    arm_clear_chk: assert property (@(posedge clk) disable iff (rst)
        arm |=> state == CAP_ARMED && fill == '0);
endmodule

// File: rtl/qcap_top.sv
module qcap_top
    import qcap_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 1024,
    parameter int N_MATCH = 2,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      arm,
    input  logic [DATA_W-1:0]         probe,
    input  logic [N_MATCH*DATA_W-1:0] cmp_val,
    input  logic [N_MATCH*DATA_W-1:0] cmp_care,
    input  logic                      qual_en,
    input  logic [N_MATCH-1:0]        qual_sel,
    input  logic [N_MATCH-1:0]        trig_sel,
    output logic                      done,
    output logic [AW:0]               stored,
    input  logic [AW-1:0]             rd_addr,
    output logic [DATA_W-1:0]         rd_data
);
    localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

    initial begin
        if (N_MATCH < 2) $error("N_MATCH must be at least 2");
    end

    logic [N_MATCH-1:0] hits;
    cap_cond_t          cond;
    cap_state_e         state;
    logic               wr_en;
    logic [AW-1:0]      wptr;
    logic [AW-1:0]      base;
    logic [AW:0]        sum;
    logic [AW-1:0]      rd_idx;

    for (genvar i = 0; i < N_MATCH; i++) begin : g_match
        qcap_match #(.DATA_W(DATA_W)) u_match (
            .probe (probe),
            .value (cmp_val[i*DATA_W +: DATA_W]),
            .care  (cmp_care[i*DATA_W +: DATA_W]),
            .hit   (hits[i])
        );
    end

    always_comb begin
        cond.qual = !qual_en || (&(hits | ~qual_sel));
        cond.trig = (|trig_sel) && (&(hits | ~trig_sel));
    end

    qcap_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .arm   (arm),
        .cond  (cond),
        .state (state),
        .wr_en (wr_en),
        .wptr  (wptr),
        .fill  (stored)
    );

    always_comb begin
        base   = (stored == FULL) ? wptr : '0;
        sum    = {1'b0, base} + {1'b0, rd_addr};
        rd_idx = (sum >= FULL) ? AW'(sum - FULL) : sum[AW-1:0];
        done   = (state == CAP_DONE);
    end

    qcap_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wptr),
        .wdata (probe),
        .rd_en (done),
        .raddr (rd_idx),
        .rdata (rd_data)
    );

    // R5
    no_empty_trig_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_sel == '0 && !done && !arm) |=> !done);
endmodule

// File: tb/test_qcap_top.sv
module test_qcap_top;
    localparam int W = 8;
    localparam int D = 1024;

    logic clk = 0;
    logic rst = 1;
    logic arm = 0;
    logic [W-1:0] probe = '0;
    logic [W-1:0] bv [2];
    logic [W-1:0] bc [2];
    logic qual_en = 0;
    logic [1:0] qual_sel = '0;
    logic [1:0] trig_sel = '0;
    logic done;
    logic [10:0] stored;
    logic [9:0] rd_addr = '0;
    logic [W-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    int q[$];
    bit m_armed = 0;
    bit m_done = 0;

    always #4 clk = ~clk;

    qcap_top i_qcap_top (
        .clk(clk), .rst(rst), .arm(arm), .probe(probe),
        .cmp_val({bv[1], bv[0]}), .cmp_care({bc[1], bc[0]}),
        .qual_en(qual_en), .qual_sel(qual_sel), .trig_sel(trig_sel),
        .done(done), .stored(stored), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit unit_hit(input int u, input logic [W-1:0] v);
        return ((v ^ bv[u]) & bc[u]) == 0;
    endfunction

    task automatic model(input logic [W-1:0] v);
        bit qa, ta;
        qa = 1; ta = (trig_sel != 0);
        for (int u = 0; u < 2; u++) begin
            if (qual_sel[u] && !unit_hit(u, v)) qa = 0;
            if (trig_sel[u] && !unit_hit(u, v)) ta = 0;
        end
        if (!qual_en) qa = 1;
        if (m_armed && !m_done) begin
            if (qa) begin
                q.push_back(int'(v));
                if (q.size() > D) void'(q.pop_front());
            end
            if (ta) m_done = 1;
        end
    endtask

    task automatic cyc(input logic [W-1:0] v);
        @(negedge clk);
        arm = 0;
        probe = v;
        model(v);
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm = 1;
        q.delete();
        m_armed = 1;
        m_done = 0;
    endtask

    task automatic finish_and_read(input string req);
        @(negedge clk);
        arm = 0;
        model(probe);
        @(negedge clk);
        chk({req, " done"}, int'(done), int'(m_done));
        chk({req, " stored"}, int'(stored), q.size());
        if (m_done) begin
            for (int i = 0; i < q.size(); i++) begin
                rd_addr = 10'(i);
                @(negedge clk);
                chk({req, " R9 readback"}, int'(rd_data), q[i]);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        bv[0] = 8'h00; bc[0] = 8'h01;
        bv[1] = 8'hFF; bc[1] = 8'hFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R9 reset done", int'(done), 0);
        chk("R9 reset stored", int'(stored), 0);
        chk("R9 reset rd_data", int'(rd_data), 0);

        // R1: unqualified storage, trigger cycle stored, later cycles ignored
        qual_en = 0; qual_sel = 2'b01; trig_sel = 2'b10;
        do_arm();
        for (int i = 0; i < 20; i++) cyc(8'(i + 3));
        rd_addr = 0;
        @(negedge clk); arm = 0; model(probe);
        chk("R9 rd_data zero while armed", int'(rd_data), 0);
        cyc(8'hFF);
        for (int i = 0; i < 5; i++) cyc(8'(i + 100));
        finish_and_read("R1");

        // R2/R4: even-only storage, trigger on unqualified odd value
        qual_en = 1;
        do_arm();
        for (int i = 0; i <= 40; i++) cyc(8'(i));
        cyc(8'hFF);
        for (int i = 0; i < 5; i++) cyc(8'(2 * i));
        finish_and_read("R4");

        // R3: care-mask sweep over all probe values
        bv[0] = 8'hA0; bc[0] = 8'hF0;
        do_arm();
        for (int i = 0; i < 255; i++) cyc(8'(i));
        cyc(8'hFF);
        finish_and_read("R3");
        chk("R3 count", q.size(), 16);

        // R5: trigger AND-ed with the qualifying unit
        bv[0] = 8'h00; bc[0] = 8'h01;
        bv[1] = 8'hF0; bc[1] = 8'hF0;
        trig_sel = 2'b11;
        do_arm();
        cyc(8'hF1);
        cyc(8'hF3);
        @(negedge clk); arm = 0; probe = 8'h10; model(8'h10);
        chk("R5 no trigger on unqualified hit", int'(done), 0);
        cyc(8'hF2);
        finish_and_read("R5");

        // R5: empty trigger select never fires; R8 rearm while armed
        bv[1] = 8'hFF; bc[1] = 8'hFF;
        qual_en = 0; trig_sel = 2'b00;
        do_arm();
        for (int i = 0; i < 256; i++) cyc(8'(i));
        @(negedge clk); arm = 0; model(probe);
        chk("R5 empty select done", int'(done), 0);
        chk("R5 empty select stored", int'(stored), 256);
        do_arm();
        @(negedge clk); arm = 0; probe = 8'h01; model(8'h01);
        chk("R8 rearm clears stored", int'(stored), 0);
        chk("R8 rearm clears done", int'(done), 0);
        trig_sel = 2'b10;
        for (int i = 0; i < 7; i++) cyc(8'(i + 50));
        cyc(8'hFF);
        finish_and_read("R8");

        // R6: dense wrap
        do_arm();
        for (int i = 0; i < 1500; i++) cyc(8'(i % 250));
        cyc(8'hFF);
        finish_and_read("R6 dense");
        chk("R6 full count", int'(stored), D);

        // R6/R2: sparse qualified events fill the memory
        qual_en = 1; qual_sel = 2'b01;
        bv[0] = 8'h07; bc[0] = 8'h07;
        do_arm();
        for (int i = 0; i < 9000; i++) cyc(8'(i % 200));
        cyc(8'hFF);
        finish_and_read("R6 sparse");
        chk("R6 sparse full", int'(stored), D);

        // R7: done holds with no further writes
        for (int i = 0; i < 10; i++) cyc(8'h07);
        @(negedge clk);
        chk("R7 done held", int'(done), 1);
        chk("R7 stored held", int'(stored), D);

        // R9: after rearm rd_data returns 0
        do_arm();
        cyc(8'h07);
        @(negedge clk);
        chk("R9 rd_data zero after rearm", int'(rd_data), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule